// File: doc/BRIEF.md
# Oversampled serial receiver with break detection and per-character error tagging

This block is the receive half of an asynchronous serial port. A free-running strobe at sixteen times the bit rate paces a small state machine. The machine qualifies a falling edge as a start bit, collects five to eight data bits, and checks an optional parity bit and the stop bit. Each finished character goes into a receive queue together with its own parity, framing and break flags. A line that stays low through a whole frame becomes a single all-zero break character. After a break, reception is suspended until the line has been seen idle (high) for two strobes.

The CPU side reads the head character through a data strobe and reads a status byte through a status strobe. The status byte shows the head character's error flags, a sticky overrun flag, a data-ready flag and a queue-wide error summary. In queue mode the storage holds sixteen characters. With queue mode off it behaves as a single holding register. Changing the mode empties the storage. A level interrupt is raised when any error flag is visible and the interrupt is enabled.

Top module: `uart_rx_brk`

## Requirements
- R1: Characters are sampled at the middle of each bit period, least significant bit first. A stored character sets status bit 0 (data ready), and `rbr_data` shows the oldest character. Bit 0 stays set until the last character is popped with `rd_rbr`.
- R2: `word_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data bits above the selected length read as zero.
- R3: With `par_en` set, a parity bit follows the data. `par_even` = 1 demands an even count of ones over data and parity, and `par_even` = 0 demands an odd count. A mismatch tags the character with a parity error, shown as status bit 2.
- R4: A low stop bit tags the character with a framing error, shown as status bit 3. This holds even when the data was all zero, as long as the line returns high before the full frame time has passed.
- R5: A line held low through the start bit, all data bits, the parity bit (if enabled) and the whole stop time (two stop bits if `stop2` is set) produces exactly one all-zero character tagged as a break, shown as status bit 4. No other character is stored while the line stays low.
- R6: After a break, no character is accepted until the line has been high on at least two consecutive strobes and a valid start bit then arrives.
- R7: Status bits 2 to 4 show only the flags of the character at the head of the queue. A pulse on `rd_lsr` clears them until a different character reaches the head.
- R8: In queue mode, status bit 7 sets when an errored character is stored and stays set until a status read. It is cleared by a status read only when no errored character remains in the queue.
- R9: With `fifo_en` low, status bit 7 reads zero.
- R10: Capacity is 16 characters with `fifo_en` high and 1 with it low. A character that arrives while the storage is full is dropped and sets status bit 1 (overrun). A status read clears bit 1.
- R11: `irq_rls` is high exactly when `rls_ie` is high and any of status bits 1 to 4 is set.
- R12: A low pulse on `sin` that has ended by mid start bit is not a start bit and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sin | input | 1 | Serial receive line, idle high |
| tick | input | 1 | Strobe at 16x the bit rate |
| word_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop2 | input | 1 | Two stop bits (stretches break time) |
| fifo_en | input | 1 | 16-entry queue mode when high |
| rls_ie | input | 1 | Line status interrupt enable |
| rd_rbr | input | 1 | Pop the head character (one cycle) |
| rd_lsr | input | 1 | Status read strobe (one cycle) |
| rbr_data | output | 8 | Head character, zero when empty |
| status | output | 8 | Bit 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 7 queue error summary, 5 and 6 zero |
| irq_rls | output | 1 | Receiver line status interrupt |

## Verification
The bench drives a line that stays low just short of the frame time and one that stays low well past it, with one and with two stop bits. A receiver that counted the frame wrongly would report a break too early or a framing error too late. After a break it sends a one-strobe high glitch followed by a long low. A receiver that re-armed at once would store extra characters there. It stacks a clean, an errored and a clean character. A design that exposed flags before they reached the head, or cleared the summary bit too early, would show the wrong bits 2 and 7. It also fills the queue past capacity in both modes. A wrong design would overwrite stored data or miss the overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef struct packed {
      logic [7:0] data;
      logic       perr;
      logic       ferr;
      logic       brk;
   } rx_char_t;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_BRK,
      RX_REARM
   } rx_state_t;

   function automatic logic char_has_err(input rx_char_t c);
      return c.perr | c.ferr | c.brk;
   endfunction

endpackage

// File: rtl/uart_rx_deframe.sv
module uart_rx_deframe
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       sin,
   input  logic [1:0] word_len,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       stop2,
   output logic       char_vld,
   output rx_char_t   char_out
);

   localparam int CW = $clog2(2 * OVS);
   localparam logic [CW-1:0] MID     = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST    = CW'(OVS - 1);
   localparam logic [CW-1:0] BRK_ONE = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] BRK_TWO = CW'(OVS / 2 + OVS - 1);

   rx_state_t      st;
   logic [CW-1:0]  cnt;
   logic [2:0]     bidx;
   logic [7:0]     shreg;
   logic           perr_q;
   logic           allz;
   logic [2:0]     last_idx;
   logic [CW-1:0]  brk_end;
   logic           ones;

   assign last_idx = 3'(word_len) + 3'd4;
   assign brk_end  = stop2 ? BRK_TWO : BRK_ONE;
   assign ones     = (^shreg) ^ sin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         cnt      <= '0;
         bidx     <= '0;
         shreg    <= '0;
         perr_q   <= 1'b0;
         allz     <= 1'b0;
         char_vld <= 1'b0;
         char_out <= '0;
      end else begin
         char_vld <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  if (!sin) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID) begin
                     cnt <= '0;
                     if (!sin) begin
                        st     <= RX_DATA;
                        bidx   <= '0;
                        shreg  <= '0;
                        perr_q <= 1'b0;
                        allz   <= 1'b1;
                     end else begin
                        st <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == LAST) begin
                     cnt         <= '0;
                     shreg[bidx] <= sin;
                     allz        <= allz & ~sin;
                     if (bidx == last_idx) st <= par_en ? RX_PAR : RX_STOP;
                     else                  bidx <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (cnt == LAST) begin
                     cnt    <= '0;
                     perr_q <= par_even ? ones : ~ones;
                     allz   <= allz & ~sin;
                     st     <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == LAST) begin
                     cnt <= '0;
                     if (sin) begin
                        char_vld <= 1'b1;
                        char_out <= '{data: shreg, perr: perr_q, ferr: 1'b0, brk: 1'b0};
                        st       <= RX_IDLE;
                     end else if (allz) begin
                        st <= RX_BRK;
                     end else begin
                        char_vld <= 1'b1;
                        char_out <= '{data: shreg, perr: perr_q, ferr: 1'b1, brk: 1'b0};
                        st       <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_BRK: begin
                  if (sin) begin
                     char_vld <= 1'b1;
                     char_out <= '{data: shreg, perr: perr_q, ferr: 1'b1, brk: 1'b0};
                     st       <= RX_IDLE;
                  end else if (cnt == brk_end) begin
                     char_vld <= 1'b1;
                     char_out <= '{data: 8'h00, perr: 1'b0, ferr: 1'b0, brk: 1'b1};
                     cnt      <= '0;
                     st       <= RX_REARM;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_REARM: begin
                  if (!sin)              cnt <= '0;
                  else if (cnt != '0)    st  <= RX_IDLE;
                  else                   cnt <= cnt + 1'b1;
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     flush,
   input  logic     deep,
   input  logic     push,
   input  rx_char_t wentry,
   input  logic     pop,
   output rx_char_t head,
   output logic     empty,
   output logic     full,
   output logic     err_any,
   output logic     push_ok,
   output logic     pop_ok
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   rx_char_t       mem [DEPTH];
   logic [AW-1:0]  wptr, rptr;
   logic [CW-1:0]  cnt, ecnt, cap;

   assign cap     = deep ? CW'(DEPTH) : CW'(1);
   assign empty   = (cnt == '0);
   assign full    = (cnt >= cap);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign head    = mem[rptr];
   assign err_any = (ecnt != '0);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_ok && wptr == AW'(g)) mem[g] <= wentry;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
         ecnt <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         cnt  <= cnt + CW'(push_ok) - CW'(pop_ok);
         ecnt <= ecnt + CW'(push_ok && char_has_err(wentry))
                      - CW'(pop_ok && char_has_err(head));
      end
   end

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
   import uart_rx_pkg::*;
#(
   parameter int OVS   = 16,
   parameter int DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sin,
   input  logic       tick,
   input  logic [1:0] word_len,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       stop2,
   input  logic       fifo_en,
   input  logic       rls_ie,
   input  logic       rd_rbr,
   input  logic       rd_lsr,
   output logic [7:0] rbr_data,
   output logic [7:0] status,
   output logic       irq_rls
);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   logic     char_vld;
   rx_char_t char_in, head;
   logic     empty, full, err_any, push_ok, pop_ok;
   logic     fifo_en_q, flush, head_chg;
   logic     ovr_q, seen_q, err7_q, show;

   uart_rx_deframe #(.OVS(OVS)) u_deframe (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .sin      (sin),
      .word_len (word_len),
      .par_en   (par_en),
      .par_even (par_even),
      .stop2    (stop2),
      .char_vld (char_vld),
      .char_out (char_in)
   );

   uart_rx_store #(.DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .deep    (fifo_en),
      .push    (char_vld),
      .wentry  (char_in),
      .pop     (rd_rbr),
      .head    (head),
      .empty   (empty),
      .full    (full),
      .err_any (err_any),
      .push_ok (push_ok),
      .pop_ok  (pop_ok)
   );

   assign flush    = fifo_en ^ fifo_en_q;
   assign head_chg = pop_ok | (push_ok & empty);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_en_q <= 1'b0;
         ovr_q     <= 1'b0;
         seen_q    <= 1'b0;
         err7_q    <= 1'b0;
      end else begin
         fifo_en_q <= fifo_en;
         if (char_vld && full)  ovr_q <= 1'b1;
         else if (rd_lsr)       ovr_q <= 1'b0;
         if (head_chg || flush) seen_q <= 1'b0;
         else if (rd_lsr)       seen_q <= 1'b1;
         if (flush)                                            err7_q <= 1'b0;
         else if (push_ok && fifo_en && char_has_err(char_in)) err7_q <= 1'b1;
         else if (rd_lsr)                                      err7_q <= err_any;
      end
   end

   assign show     = ~empty & ~seen_q;
   assign rbr_data = empty ? 8'h00 : head.data;
   assign status   = {err7_q & fifo_en, 2'b00,
                      head.brk & show, head.ferr & show, head.perr & show,
                      ovr_q, ~empty};
   assign irq_rls  = rls_ie & (|status[4:1]);

endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_en,
   input logic       rls_ie,
   input logic       rd_rbr,
   input logic       rd_lsr,
   input logic [7:0] status,
   input logic       irq_rls
);

   assert_dr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] && !rd_rbr && fifo_en == $past(fifo_en) |=> status[0]);

   assert_head_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lsr && !rd_rbr && status[0] |=> status[4:2] == 3'b000);

   assert_sum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] && !rd_lsr |=> status[7] || !fifo_en);

   assert_no_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> !status[7]);

   assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rls_ie |-> !irq_rls);

   assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rls |-> |status[4:1]);

endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fifo_en (fifo_en),
   .rls_ie  (rls_ie),
   .rd_rbr  (rd_rbr),
   .rd_lsr  (rd_lsr),
   .status  (status),
   .irq_rls (irq_rls)
);

// File: tb/sim_uart_rx_brk.sv
module sim_uart_rx_brk;

   localparam int CLK_PERIOD = 10;
   localparam int BITCLK     = 32;   // 16 strobes, one every 2 clocks

   logic       clk = 1'b0;
   logic       rst_n, sin, tick;
   logic [1:0] word_len;
   logic       par_en, par_even, stop2, fifo_en, rls_ie, rd_rbr, rd_lsr;
   logic [7:0] rbr_data, status;
   logic       irq_rls;
   logic [7:0] cyc = '0;
   int         nchk = 0, nfail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;
   always_ff @(posedge clk) cyc <= cyc + 1'b1;
   assign tick = cyc[0];

   uart_rx_brk u0 (
      .clk(clk), .rst_n(rst_n), .sin(sin), .tick(tick), .word_len(word_len),
      .par_en(par_en), .par_even(par_even), .stop2(stop2), .fifo_en(fifo_en),
      .rls_ie(rls_ie), .rd_rbr(rd_rbr), .rd_lsr(rd_lsr),
      .rbr_data(rbr_data), .status(status), .irq_rls(irq_rls)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int clocks);
      sin = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input int nb, input bit bad_par, input logic stop_v);
      logic [7:0] m;
      logic       p;
      m = 8'hFF >> (8 - nb);
      hold(1'b0, BITCLK);
      for (int i = 0; i < nb; i++) hold(d[i], BITCLK);
      if (par_en) begin
         p = ^(d & m);
         hold((par_even ? p : ~p) ^ bad_par, BITCLK);
      end
      hold(stop_v, BITCLK);
      hold(1'b1, 2 * BITCLK);
   endtask

   task automatic read_lsr(output logic [7:0] s);
      s = status;
      rd_lsr = 1'b1;
      @(negedge clk);
      rd_lsr = 1'b0;
   endtask

   task automatic pop(output logic [7:0] d);
      d = rbr_data;
      rd_rbr = 1'b1;
      @(negedge clk);
      rd_rbr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 reset status", status, 8'h00);
      chk("R11 reset irq", irq_rls, 1'b0);
   endtask

   task automatic t_basic;
      logic [7:0] d;
      send_char(8'hA5, 8, 0, 1'b1);
      send_char(8'h01, 8, 0, 1'b1);
      chk("R1 ready", status, 8'h01);
      pop(d); chk("R1 first data lsb-first", d, 8'hA5);
      pop(d); chk("R1 second data", d, 8'h01);
      chk("R1 ready clears", status, 8'h00);
   endtask

   task automatic t_wordlen;
      logic [7:0] d;
      word_len = 2'd0; send_char(8'h15, 5, 0, 1'b1);
      word_len = 2'd1; send_char(8'h2A, 6, 0, 1'b1);
      pop(d); chk("R2 five bits", d, 8'h15);
      pop(d); chk("R2 six bits", d, 8'h2A);
      word_len = 2'd3;
   endtask

   task automatic t_parity;
      logic [7:0] d, s;
      par_en = 1'b1; par_even = 1'b0; word_len = 2'd2;
      send_char(8'h5B, 7, 0, 1'b1);
      send_char(8'h5B, 7, 1, 1'b1);
      chk("R7 head clean hides later error", status, 8'h81);
      pop(d); chk("R3 odd good data", d, 8'h5B);
      chk("R3 parity error at head", status, 8'h85);
      #1 chk("R11 irq on parity", irq_rls, 1'b1);
      read_lsr(s);
      chk("R7 read clears head flag, R8 summary kept", status, 8'h81);
      pop(d);
      chk("R8 summary sticky until read", status, 8'h80);
      read_lsr(s);
      chk("R8 summary clears when none remain", status, 8'h00);
      par_even = 1'b1; word_len = 2'd3;
      send_char(8'h33, 8, 0, 1'b1);
      chk("R3 even parity good", status, 8'h01);
      pop(d); chk("R3 even data", d, 8'h33);
      par_en = 1'b0;
   endtask

   task automatic t_frame;
      logic [7:0] d, s;
      send_char(8'h81, 8, 0, 1'b0);
      chk("R4 framing error", status, 8'h89);
      pop(d); chk("R4 framing data", d, 8'h81);
      read_lsr(s);
      hold(1'b0, 312); hold(1'b1, 2 * BITCLK);
      chk("R5 short low is framing not break", status, 8'h89);
      pop(d); chk("R4 short low data zero", d, 8'h00);
      read_lsr(s);
      chk("R4 cleared", status, 8'h00);
   endtask

   task automatic t_break;
      logic [7:0] d, s;
      hold(1'b0, 14 * BITCLK); hold(1'b1, 3 * BITCLK);
      chk("R5 break status", status, 8'h91);
      #1 chk("R11 irq on break", irq_rls, 1'b1);
      read_lsr(s);
      chk("R7 read clears break flag", status, 8'h81);
      pop(d); chk("R5 break char zero", d, 8'h00);
      chk("R5 exactly one break char", status, 8'h80);
      read_lsr(s);
      stop2 = 1'b1;
      hold(1'b0, 336); hold(1'b1, 3 * BITCLK);
      chk("R5 two stop bits: 10.5 bits low is framing", status, 8'h89);
      pop(d); read_lsr(s);
      hold(1'b0, 12 * BITCLK); hold(1'b1, 3 * BITCLK);
      chk("R5 two stop bits: 12 bits low is break", status, 8'h91);
      pop(d); read_lsr(s);
      chk("R5 cleared", status, 8'h00);
      stop2 = 1'b0;
   endtask

   task automatic t_rearm;
      logic [7:0] d, s;
      hold(1'b0, 14 * BITCLK);
      pop(d); chk("R5 break before rearm", d, 8'h00);
      read_lsr(s);
      hold(1'b1, 2);
      hold(1'b0, 10 * BITCLK);
      hold(1'b1, 2 * BITCLK);
      chk("R6 no char after one-strobe high", status, 8'h00);
      send_char(8'h3C, 8, 0, 1'b1);
      chk("R6 char after rearm", status, 8'h01);
      pop(d); chk("R6 rearm data", d, 8'h3C);
      chk("R6 only one char", status, 8'h00);
   endtask

   task automatic t_glitch;
      hold(1'b0, 8); hold(1'b1, 2 * BITCLK);
      chk("R12 glitch ignored", status, 8'h00);
   endtask

   task automatic t_overrun;
      logic [7:0] d, s;
      for (int i = 0; i < 17; i++) send_char(8'h40 + 8'(i), 8, 0, 1'b1);
      chk("R10 overrun in queue mode", status, 8'h03);
      #1 chk("R11 irq on overrun", irq_rls, 1'b1);
      read_lsr(s);
      chk("R10 overrun cleared by read", status, 8'h01);
      for (int i = 0; i < 16; i++) begin
         pop(d); chk("R10 stored order, 17th dropped", d, 8'h40 + 8'(i));
      end
      chk("R10 queue drained", status, 8'h00);
   endtask

   task automatic t_nonfifo;
      logic [7:0] d, s;
      fifo_en = 1'b0; hold(1'b1, 4);
      par_en = 1'b1; par_even = 1'b1;
      send_char(8'h0F, 8, 1, 1'b1);
      chk("R9 no summary bit in single mode", status, 8'h05);
      send_char(8'h70, 8, 0, 1'b1);
      chk("R10 overrun with capacity one", status, 8'h07);
      rls_ie = 1'b0;
      #1 chk("R11 irq masked", irq_rls, 1'b0);
      rls_ie = 1'b1;
      #1 chk("R11 irq enabled", irq_rls, 1'b1);
      @(negedge clk);
      pop(d); chk("R10 held char kept", d, 8'h0F);
      chk("R10 overrun sticky after pop", status, 8'h02);
      read_lsr(s);
      chk("R10 cleared", status, 8'h00);
      par_en = 1'b0; fifo_en = 1'b1; hold(1'b1, 4);
   endtask

   initial begin
      rst_n = 1'b0; sin = 1'b1; word_len = 2'd3; par_en = 1'b0; par_even = 1'b0;
      stop2 = 1'b0; fifo_en = 1'b1; rls_ie = 1'b1; rd_rbr = 1'b0; rd_lsr = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      hold(1'b1, 2 * BITCLK);
      t_reset;
      t_basic;
      t_wordlen;
      t_parity;
      t_frame;
      t_break;
      t_rearm;
      t_glitch;
      t_overrun;
      t_nonfifo;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule